// File: doc/BRIEF.md
# Phase-Shifted Five-Level PWM Modulator

This block produces the eight gate signals of a five-level, capacitor-clamped buck DC-DC stage. The stage has four independently switched legs. Each leg drives one main switch and one complementary switch. One up/down position counter yields four triangular carriers of equal period. Each carrier is a quarter period ahead of the one before it, so the unfiltered stage output steps at four times the carrier rate. Each leg compares its own carrier against its own duty value. That value is a common duty word plus a signed balancing offset. The fourth leg takes the negated offset of the first, so the outer capacitor pair can be trimmed without moving the mean output.

A control loop outside this block supplies the common duty and three balancing offsets. The block clamps each leg's duty to the range 0 to full scale. It takes a new value into a leg only at that leg's carrier valley. It inserts a programmable dead time before every turn-on, so the two switches of a pair never conduct together. A one-cycle strobe marks the start of each period of the first carrier. With enable low, every gate is held off.

Top module: `pwm5l_modulator`

## Requirements
- R1: While `rst_i` is high, all eight gate bits and `sync_o` are low. After `rst_i` is released, `sync_o` is high in the first cycle.
- R2: `sync_o` is high for exactly one cycle out of every 2·2^DW cycles (128 by default).
- R3: The carrier of leg k (k = 0..3) runs k·2^(DW-1) cycles ahead of the carrier of leg 0. With equal duties, each rising edge of leg k's main gate comes that many cycles before the matching edge of leg 0, modulo the period.
- R4: Leg duties are formed as follows: leg 0 = `duty_i` + `bal_a_i`, leg 1 = `duty_i` + `bal_b_i`, leg 2 = `duty_i` + `bal_c_i`, leg 3 = `duty_i` − `bal_a_i`. The offsets are two's complement.
- R5: Each leg duty is clamped to the range 0 to F, where F = 2^DW. A leg clamped at F keeps its main gate on and its complement off for the whole period. A leg clamped at 0 does the reverse.
- R6: For a leg duty d with 0 < d < F and `dead_i` = T, the main gate is on for 2d−(T+1) cycles per period and the complement for 2(F−d)−(T+1) cycles. The main pulse is centred on the carrier peak.
- R7: Gate bits 0, 1, 6 and 7 are the main gates of legs 0, 1, 2 and 3. Gate bits 2, 3, 4 and 5 are their complements, in the same leg order.
- R8: The two gates of a leg are never on together. Every turn-on is preceded by exactly `dead_i`+1 cycles with both gates of that leg off, so a leg with 0 < d < F spends 2(`dead_i`+1) cycles per period with both off.
- R9: A leg takes a new duty only in the last cycle of its own carrier period. A change to the inputs during a period does not alter that period's pulse.
- R10: One cycle after `en_i` is sampled low, all gates are off. After `en_i` returns high, no gate turns on for `dead_i`+1 cycles.
- R11: With all four leg duties equal to d, no more than ceil(4d/F) main gates are on in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Gate enable; low forces all gates off |
| duty_i | input | DW+1 | Common duty word, full scale F = 2^DW |
| bal_a_i | input | OW | Signed offset, added to leg 0 and subtracted from leg 3 |
| bal_b_i | input | OW | Signed offset for leg 1 |
| bal_c_i | input | OW | Signed offset for leg 2 |
| dead_i | input | TW | Dead time; each turn-on waits dead_i+1 cycles |
| gate_o | output | 8 | Gate drives, bit map as in R7 |
| sync_o | output | 1 | One-cycle strobe at the start of leg 0's carrier period |

## Verification
The embedded properties check the following on every cycle: the counter steps by one and wraps, the strobe is one cycle wide, the two gates of a leg never overlap, and no turn-on directly follows the partner being on. They also check that a leg's latched duty moves only at its valley and never exceeds full scale, and that all gates are dark after enable drops. Pulse widths per period, the quarter-period carrier spacing, the offset arithmetic and its clamping, and the gate-bit map need whole-period measurement, so only the bench scenarios show them. The same holds for deferral of a mid-period duty change, the re-enable delay and the per-region limit on simultaneous main gates.

// File: rtl/pwm5l_pkg.sv
package pwm5l_pkg;

    // number of independently modulated legs
    localparam int unsigned LEGS = 4;

    // requested state of one switch pair
    typedef enum logic [1:0] {
        WANT_OFF  = 2'd0,
        WANT_MAIN = 2'd1,
        WANT_COMP = 2'd2
    } want_e;

endpackage

// File: rtl/pwm5l_carrier.sv
module pwm5l_carrier
    import pwm5l_pkg::*;
#(
    parameter int unsigned DW = 6
) (
    input  logic                     clk_i,
    input  logic                     rst_i,
    output logic [LEGS-1:0][DW:0]    pos_o,
    output logic                     sync_o
);
    localparam int unsigned PW   = DW + 1;
    localparam logic [PW-1:0] LAST = '1;

    typedef struct packed {
        logic [PW-1:0] cnt;
    } car_st_t;

    car_st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s_q.cnt <= LAST;
        end else begin
            s_q <= s_d;
        end
    end

    // phase copies: leg k is k quarter periods ahead
    for (genvar k = 0; k < LEGS; k++) begin : g_phase
        localparam logic [PW-1:0] OFS = PW'(k * (1 << (DW - 1)));
        assign pos_o[k] = s_q.cnt + OFS;
    end

    assign sync_o = (s_q.cnt == '0);

    p_step_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (s_q.cnt != LAST) |=> (s_q.cnt == $past(s_q.cnt) + 1'b1));

    p_wrap_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (s_q.cnt == LAST) |=> (s_q.cnt == '0));

    p_sync_single_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        sync_o |=> !sync_o);

endmodule

// File: rtl/pwm5l_duty.sv
module pwm5l_duty
    import pwm5l_pkg::*;
#(
    parameter int unsigned DW = 6,
    parameter int unsigned OW = 8
) (
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  logic [DW:0]              duty_i,
    input  logic signed [OW-1:0]     bal_a_i,
    input  logic signed [OW-1:0]     bal_b_i,
    input  logic signed [OW-1:0]     bal_c_i,
    input  logic [LEGS-1:0][DW:0]    pos_i,
    output logic [LEGS-1:0][DW:0]    duty_o
);
    localparam int unsigned SW = DW + 3;
    localparam int unsigned F  = 1 << DW;
    localparam logic [DW:0] LAST = '1;
    localparam logic signed [SW-1:0] FS = SW'(F);

    typedef struct packed {
        logic [LEGS-1:0][DW:0] duty;
    } duty_st_t;

    duty_st_t s_d, s_q;

    logic signed [SW-1:0] base;
    logic signed [SW-1:0] ext_a, ext_b, ext_c;
    logic [LEGS-1:0][DW:0] target;

    function automatic logic [DW:0] clamp(input logic signed [SW-1:0] v);
        if (v < 0) begin
            return '0;
        end else if (v > FS) begin
            return (DW+1)'(F);
        end else begin
            return v[DW:0];
        end
    endfunction

    always_comb begin
        base  = signed'({2'b00, duty_i});
        ext_a = SW'(bal_a_i);
        ext_b = SW'(bal_b_i);
        ext_c = SW'(bal_c_i);
        target[0] = clamp(base + ext_a);
        target[1] = clamp(base + ext_b);
        target[2] = clamp(base + ext_c);
        target[3] = clamp(base - ext_a);

        s_d = s_q;
        for (int k = 0; k < LEGS; k++) begin
            // take a new value only as the leg's carrier leaves its valley
            if (pos_i[k] == LAST) begin
                s_d.duty[k] = target[k];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s_q.duty <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign duty_o = s_q.duty;

    for (genvar k = 0; k < LEGS; k++) begin : g_chk
        p_duty_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
            (pos_i[k] != LAST) |=> $stable(duty_o[k]));

        p_duty_cap_r5: assert property (@(posedge clk_i) disable iff (rst_i)
            duty_o[k] <= (DW+1)'(F));
    end

endmodule

// File: rtl/pwm5l_leg.sv
module pwm5l_leg
    import pwm5l_pkg::*;
#(
    parameter int unsigned DW = 6,
    parameter int unsigned TW = 4
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic           en_i,
    input  logic [TW-1:0]  dead_i,
    input  logic [DW:0]    pos_i,
    input  logic [DW:0]    duty_i,
    output logic           main_o,
    output logic           comp_o
);
    localparam int unsigned F = 1 << DW;

    typedef struct packed {
        logic          raw;
        want_e         want;
        logic [TW-1:0] cnt;
        logic          main;
        logic          comp;
    } leg_st_t;

    leg_st_t s_d, s_q;

    logic [DW-1:0] carr;
    logic [DW+1:0] sum;
    want_e         want_now;

    always_comb begin
        s_d = s_q;

        // triangle: rising in first half, falling in second half
        carr  = pos_i[DW] ? ~pos_i[DW-1:0] : pos_i[DW-1:0];
        sum   = {2'b00, carr} + {1'b0, duty_i};
        s_d.raw = (sum >= (DW+2)'(F));

        if (!en_i) begin
            want_now = WANT_OFF;
        end else if (s_q.raw) begin
            want_now = WANT_MAIN;
        end else begin
            want_now = WANT_COMP;
        end
        s_d.want = want_now;

        if (want_now != s_q.want) begin
            s_d.cnt  = '0;
            s_d.main = 1'b0;
            s_d.comp = 1'b0;
        end else if (s_q.cnt < dead_i) begin
            s_d.cnt  = s_q.cnt + 1'b1;
            s_d.main = 1'b0;
            s_d.comp = 1'b0;
        end else begin
            s_d.main = (want_now == WANT_MAIN);
            s_d.comp = (want_now == WANT_COMP);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s_q.raw  <= 1'b0;
            s_q.want <= WANT_OFF;
            s_q.cnt  <= '0;
            s_q.main <= 1'b0;
            s_q.comp <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign main_o = s_q.main;
    assign comp_o = s_q.comp;

    p_no_overlap_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        !(main_o && comp_o));

    p_gap_main_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(main_o) |-> !$past(comp_o));

    p_gap_comp_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(comp_o) |-> !$past(main_o));

    p_off_disabled_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> (!main_o && !comp_o));

endmodule

// File: rtl/pwm5l_modulator.sv
module pwm5l_modulator
    import pwm5l_pkg::*;
#(
    parameter int unsigned DW = 6,
    parameter int unsigned OW = 8,
    parameter int unsigned TW = 4
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 en_i,
    input  logic [DW:0]          duty_i,
    input  logic signed [OW-1:0] bal_a_i,
    input  logic signed [OW-1:0] bal_b_i,
    input  logic signed [OW-1:0] bal_c_i,
    input  logic [TW-1:0]        dead_i,
    output logic [7:0]           gate_o,
    output logic                 sync_o
);
    logic [LEGS-1:0][DW:0] pos_w;
    logic [LEGS-1:0][DW:0] duty_w;

    pwm5l_carrier #(.DW(DW)) i_carrier (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .pos_o  (pos_w),
        .sync_o (sync_o)
    );

    pwm5l_duty #(.DW(DW), .OW(OW)) i_duty (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .duty_i  (duty_i),
        .bal_a_i (bal_a_i),
        .bal_b_i (bal_b_i),
        .bal_c_i (bal_c_i),
        .pos_i   (pos_w),
        .duty_o  (duty_w)
    );

    // main gates on bits 0,1,6,7; complements on bits 2..5 in leg order
    for (genvar k = 0; k < LEGS; k++) begin : g_leg
        localparam int MI = (k < 2) ? k : k + 4;
        localparam int CI = k + 2;
        logic main_w, comp_w;

        pwm5l_leg #(.DW(DW), .TW(TW)) i_leg (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .en_i   (en_i),
            .dead_i (dead_i),
            .pos_i  (pos_w[k]),
            .duty_i (duty_w[k]),
            .main_o (main_w),
            .comp_o (comp_w)
        );

        assign gate_o[MI] = main_w;
        assign gate_o[CI] = comp_w;
    end

endmodule

// File: tb/test_pwm5l_modulator.sv
module test_pwm5l_modulator;
    localparam int DW  = 6;
    localparam int OW  = 8;
    localparam int TW  = 4;
    localparam int F   = 1 << DW;
    localparam int PER = 2 * F;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 en  = 1'b0;
    logic [DW:0]          duty = '0;
    logic signed [OW-1:0] ba = '0, bb = '0, bc = '0;
    logic [TW-1:0]        dead = TW'(2);
    logic [7:0]           gate;
    logic                 sync;

    always #10 clk = ~clk;

    pwm5l_modulator #(.DW(DW), .OW(OW), .TW(TW)) i_pwm5l_modulator (
        .clk_i   (clk),
        .rst_i   (rst),
        .en_i    (en),
        .duty_i  (duty),
        .bal_a_i (ba),
        .bal_b_i (bb),
        .bal_c_i (bc),
        .dead_i  (dead),
        .gate_o  (gate),
        .sync_o  (sync)
    );

    int nchk = 0, nfail = 0;
    bit done = 0;
    bit busy = 0;
    int cur_d = 0, cur_a = 0, cur_b = 0, cur_c = 0, cur_t = 2;

    typedef struct {
        int    leg;
        int    mn;
        int    cp;
        int    bo;
        string req;
    } exp_t;
    exp_t sb[$];

    function automatic int clampf(int v);
        if (v < 0) return 0;
        if (v > F) return F;
        return v;
    endfunction

    function automatic int mbit(int k);
        return (k < 2) ? k : k + 4;
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic apply(int d, int a, int b, int c, int t);
        @(negedge clk);
        duty = (DW+1)'(d);
        ba = OW'(a); bb = OW'(b); bc = OW'(c);
        dead = TW'(t);
        cur_d = d; cur_a = a; cur_b = b; cur_c = c; cur_t = t;
        repeat (3 * PER) @(negedge clk);
    endtask

    // driver: push expected per-leg counts for the current settings
    task automatic expect_legs(string req);
        int ld[4];
        ld[0] = clampf(cur_d + cur_a);
        ld[1] = clampf(cur_d + cur_b);
        ld[2] = clampf(cur_d + cur_c);
        ld[3] = clampf(cur_d - cur_a);
        for (int k = 0; k < 4; k++) begin
            exp_t it;
            it.leg = k;
            it.req = req;
            if (ld[k] == 0) begin
                it.mn = 0; it.cp = PER; it.bo = 0;
            end else if (ld[k] == F) begin
                it.mn = PER; it.cp = 0; it.bo = 0;
            end else begin
                it.mn = 2 * ld[k] - (cur_t + 1);
                it.cp = 2 * (F - ld[k]) - (cur_t + 1);
                it.bo = 2 * (cur_t + 1);
            end
            sb.push_back(it);
        end
        do @(negedge clk); while (sb.size() != 0 || busy);
    endtask

    // monitor: measure one period per expected item and compare
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() != 0) begin
                exp_t it;
                int m, c, b, o;
                busy = 1;
                it = sb.pop_front();
                m = 0; c = 0; b = 0; o = 0;
                for (int i = 0; i < PER; i++) begin
                    if (i != 0) @(negedge clk);
                    if (gate[mbit(it.leg)]) m++;
                    if (gate[it.leg + 2]) c++;
                    if (!gate[mbit(it.leg)] && !gate[it.leg + 2]) b++;
                    if (gate[mbit(it.leg)] && gate[it.leg + 2]) o++;
                end
                check(m == it.mn, {it.req, " main on-time"}, m, it.mn);
                check(c == it.cp, {it.req, " complement on-time"}, c, it.cp);
                check(b == it.bo, "R8 both-off cycles", b, it.bo);
                check(o == 0, "R8 overlap cycles", o, 0);
                busy = 0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog (all requirements): actual %0d cycles expected completion", 150000);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        int rise[4];
        logic [7:0] prev;
        int cnt, mx, on, lim, diff;

        // R1: reset state
        repeat (4) @(negedge clk);
        check(gate == 8'h00, "R1 gates in reset", int'(gate), 0);
        check(sync == 1'b0, "R1 sync in reset", int'(sync), 0);
        rst = 1'b0;
        @(negedge clk);
        check(sync == 1'b1, "R1 sync after release", int'(sync), 1);

        // R2: strobe period
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (!sync);
        check(cnt == PER, "R2 sync period", cnt, PER);

        en = 1'b1;
        // R6 R7: mid-scale, no offsets
        apply(32, 0, 0, 0, 2);
        expect_legs("R6 R7");

        // R3: quarter-period spacing
        for (int k = 0; k < 4; k++) rise[k] = -1;
        prev = gate;
        for (int i = 1; i <= 2 * PER; i++) begin
            @(negedge clk);
            for (int k = 0; k < 4; k++)
                if (rise[k] < 0 && gate[mbit(k)] && !prev[mbit(k)]) rise[k] = i;
            prev = gate;
        end
        for (int k = 1; k < 4; k++) begin
            diff = ((rise[0] - rise[k]) % PER + PER) % PER;
            check(diff == 32 * k, "R3 carrier lead", diff, 32 * k);
        end

        // R4: distinct offsets, leg 3 mirrors leg 0
        apply(16, 8, -4, 20, 2);
        expect_legs("R4");

        // R5: clamp at full scale and at zero
        apply(60, 10, -62, 0, 2);
        expect_legs("R5 high clamp");
        apply(0, -10, 0, 5, 2);
        expect_legs("R5 low clamp");
        apply(127, -40, 0, -63, 2);
        expect_legs("R5 oversize word");

        // R6 R8: other dead times
        apply(32, 0, 0, 0, 7);
        expect_legs("R6 dead 7");
        apply(32, 0, 0, 0, 0);
        expect_legs("R6 dead 0");

        // R9: mid-period change deferred to next period
        apply(32, 0, 0, 0, 2);
        do @(negedge clk); while (!sync);
        @(negedge clk);
        duty = (DW+1)'(16);
        cnt = 0;
        for (int i = 0; i < PER; i++) begin @(negedge clk); if (gate[0]) cnt++; end
        check(cnt == 61, "R9 current period keeps old duty", cnt, 61);
        cnt = 0;
        for (int i = 0; i < PER; i++) begin @(negedge clk); if (gate[0]) cnt++; end
        check(cnt == 29, "R9 next period uses new duty", cnt, 29);

        // R10: disable and re-enable
        apply(32, 0, 0, 0, 5);
        en = 1'b0;
        cnt = 0;
        for (int i = 0; i < PER + 2; i++) begin @(negedge clk); if (gate != 8'h00) cnt++; end
        check(cnt == 0, "R10 gates off while disabled", cnt, 0);
        en = 1'b1;
        cnt = 0;
        for (int i = 0; i < 6; i++) begin @(negedge clk); if (gate != 8'h00) cnt++; end
        check(cnt == 0, "R10 dead time after enable", cnt, 0);
        @(negedge clk);
        on = $countones(gate);
        check(on >= 2, "R10 gates return after dead time", on, 2);

        // R11: simultaneous main gates per region
        foreach (rise[j]) rise[j] = 0;
        for (int r = 0; r < 3; r++) begin
            int d;
            d = 8 + 16 * r * 1 + ((r == 2) ? 16 : 0);
            apply(d, 0, 0, 0, 2);
            lim = (4 * d + F - 1) / F;
            mx = 0;
            for (int i = 0; i < PER; i++) begin
                @(negedge clk);
                on = int'(gate[0]) + int'(gate[1]) + int'(gate[6]) + int'(gate[7]);
                if (on > mx) mx = on;
            end
            check(mx <= lim, "R11 main gates on at once", mx, lim);
        end

        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule